// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. The transmit path and the receive path run on their own and at the same time. Each path has two stages. On the transmit side a holding register feeds a frame shifter, so the next character can be loaded while the current one is still going out. On the receive side a frame collector hands each finished character to a data register, which the consumer reads while the next frame arrives.

The character format is chosen at run time from three controls: 7 or 8 data bits, no parity or even or odd parity, and one or two stop bits. That gives twelve formats. Bit timing comes from an enable pulse `tick16_i` at sixteen times the bit rate, supplied from outside. The receiver aligns to the falling edge of the start bit and takes each bit in the middle of its cell. It checks the start bit again at its centre to reject glitches, and it reports parity, framing and overrun errors with each character. The format controls must stay stable while a frame is in flight.

Top module: `sp_port`

## Requirements
- R1: After reset, and whenever nothing is queued or sending, `txd_o` is high (mark), `tx_empty_o` and `tx_end_o` are 1 and `rx_full_o` is 0.
- R2: A transmitted frame is, in time order: one low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits, all high. Every bit after the start bit lasts exactly 16 `tick16_i` pulses.
- R3: `cfg_len8_i`=1 selects 8 data bits and 0 selects 7 (bits 6..0). `cfg_par_en_i`=1 adds a parity bit. `cfg_stop2_i`=1 sends two stop bits and 0 sends one. All 12 combinations work on both paths.
- R4: With `cfg_par_odd_i`=0 the parity bit makes the count of ones over data plus parity even. With 1 it makes that count odd.
- R5: A write (`tx_wr_i`) loads the holding register only when `tx_empty_o` is 1. A write while it is 0 is ignored. The held character moves to the shifter as soon as the shifter is free or finishing, so queued frames follow each other with no idle gap.
- R6: `tx_end_o` is 0 while a frame is on the line or a character is held. It becomes 1 only after the last stop bit with the holding register empty.
- R7: The receiver starts on a low line while idle and samples on the 8th tick counted from the detecting tick, then every 16 ticks. If the start bit reads high at its centre, the frame is dropped and nothing is loaded.
- R8: When the first stop bit has been sampled, the character goes to `rx_data_o` and `rx_full_o` rises. `rx_rd_i` clears `rx_full_o`.
- R9: `rx_perr_o` is 1 for a loaded character whose received parity bit disagrees with the parity selected by R4, and 0 otherwise or when parity is off.
- R10: `rx_ferr_o` is 1 for a loaded character whose first stop bit was sampled low.
- R11: If a frame completes while `rx_full_o` is 1 and no read is made in that cycle, `rx_oerr_o` is set and `rx_data_o` keeps the unread character. `rx_rd_i` clears `rx_oerr_o`.
- R12: In 7-bit mode bit 7 of `rx_data_o` is 0.
- R13: A frame can be transmitted and a different frame received at the same time without either one being disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulse at 16x the bit rate |
| cfg_len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2_i | input | 1 | 1: two stop bits, 0: one |
| tx_data_i | input | 8 | Character to send |
| tx_wr_i | input | 1 | Write strobe for the holding register |
| tx_empty_o | output | 1 | Holding register free |
| tx_end_o | output | 1 | Transmitter fully idle |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line (synchronised inside) |
| rx_rd_i | input | 1 | Read strobe, clears full and overrun |
| rx_data_o | output | 8 | Received character |
| rx_full_o | output | 1 | Unread character present |
| rx_perr_o | output | 1 | Parity error of the held character |
| rx_ferr_o | output | 1 | Framing error of the held character |
| rx_oerr_o | output | 1 | Overrun occurred |

## Verification
A write sets the holding register at the next edge. The shifter takes the character one edge later, so `txd_o` falls two clocks after the write strobe. Each later bit lasts exactly 64 clocks at the bench's one-tick-per-four-clocks rate. The bench waits for the start edge, moves 30 clocks in and samples every 64 clocks, which stays clear of every bit boundary. `rx_full_o` rises after two synchroniser clocks plus eight ticks into the first stop bit, so the bench checks the receive outputs only after the whole stop period has passed. It drives its own frames on the line, and it measures the gap between queued frames by counting the clocks from the last stop-bit sample to the next falling edge.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned OVS     = 16;
  localparam int unsigned TCNT_W  = $clog2(OVS);
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned IDX_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
    logic stop2;
  } sp_cfg_t;

  typedef enum logic {RX_IDLE, RX_RUN} rx_st_e;

  function automatic int unsigned n_data(sp_cfg_t c);
    return c.len8 ? DATA_W : DATA_W - 1;
  endfunction

  function automatic logic [DATA_W-1:0] mask_data(logic [DATA_W-1:0] d, sp_cfg_t c);
    return c.len8 ? d : {1'b0, d[DATA_W-2:0]};
  endfunction

  function automatic logic par_bit(logic [DATA_W-1:0] d, sp_cfg_t c);
    return (^mask_data(d, c)) ^ c.par_odd;
  endfunction

  // total bits on the line, start bit included
  function automatic logic [IDX_W-1:0] tx_len(sp_cfg_t c);
    return IDX_W'(2 + n_data(c) + int'(c.par_en) + int'(c.stop2));
  endfunction

  // sample index of the first stop bit
  function automatic logic [IDX_W-1:0] rx_last(sp_cfg_t c);
    return IDX_W'(1 + n_data(c) + int'(c.par_en));
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, sp_cfg_t c);
    logic [FRAME_W-1:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(n_data(c))) f[i+1] = d[i];
    if (c.par_en)
      for (int i = 0; i < FRAME_W; i++)
        if (i == int'(n_data(c)) + 1) f[i] = par_bit(d, c);
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] get_data(logic [FRAME_W-1:0] v, sp_cfg_t c);
    logic [DATA_W-1:0] d;
    d = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(n_data(c))) d[i] = v[i+1];
    return d;
  endfunction

  function automatic logic get_par(logic [FRAME_W-1:0] v, sp_cfg_t c);
    logic p;
    p = 1'b0;
    for (int i = 0; i < FRAME_W; i++)
      if (i == int'(n_data(c)) + 1) p = v[i];
    return p;
  endfunction
endpackage

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  sp_cfg_t           cfg_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              end_o
);
  logic [DATA_W-1:0]  hold_q;
  logic               hold_full_q;
  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   bits_q;
  logic [TCNT_W-1:0]  tcnt_q;
  logic               bit_end, last_bit, load;

  assign bit_end  = busy_q && tick_i && (tcnt_q == TCNT_W'(OVS - 1));
  assign last_bit = bit_end && (bits_q == IDX_W'(1));
  assign load     = hold_full_q && (!busy_q || last_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      sh_q        <= '1;
      bits_q      <= '0;
      tcnt_q      <= '0;
    end else begin
      if (wr_i && !hold_full_q) begin
        hold_q      <= data_i;
        hold_full_q <= 1'b1;
      end
      if (load) begin
        // chain straight into the next frame: no idle cell
        sh_q        <= build_frame(hold_q, cfg_i);
        bits_q      <= tx_len(cfg_i);
        tcnt_q      <= '0;
        busy_q      <= 1'b1;
        hold_full_q <= 1'b0;
      end else if (busy_q && tick_i) begin
        tcnt_q <= tcnt_q + 1'b1;
        if (bit_end) begin
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          bits_q <= bits_q - 1'b1;
          if (last_bit) busy_q <= 1'b0;
        end
      end
    end
  end

  assign txd_o   = busy_q ? sh_q[0] : 1'b1;
  assign empty_o = !hold_full_q;
  assign end_o   = !busy_q && !hold_full_q;
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  sp_cfg_t           cfg_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              oerr_o
);
  localparam logic [TCNT_W-1:0] MID = TCNT_W'(OVS / 2 - 1);

  rx_st_e             st_q;
  logic [TCNT_W-1:0]  tcnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] vec_q;
  logic [DATA_W-1:0]  data_q, nxt_data;
  logic               full_q, perr_q, ferr_q, oerr_q;
  logic               nxt_perr;

  assign nxt_data = get_data(vec_q, cfg_i);
  assign nxt_perr = cfg_i.par_en && (get_par(vec_q, cfg_i) != par_bit(nxt_data, cfg_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      idx_q  <= '0;
      vec_q  <= '1;
      data_q <= '0;
      full_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      oerr_q <= 1'b0;
    end else begin
      if (rd_i) begin
        full_q <= 1'b0;
        oerr_q <= 1'b0;
      end
      if (tick_i) begin
        case (st_q)
          RX_IDLE: if (!rxd_i) begin
            st_q   <= RX_RUN;
            tcnt_q <= TCNT_W'(1);  // detecting tick counts as the first
            idx_q  <= '0;
          end
          default: begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == MID) begin
              if (idx_q == '0 && rxd_i) begin
                st_q <= RX_IDLE;  // start bit gone at centre: glitch
              end else if (idx_q == rx_last(cfg_i)) begin
                st_q <= RX_IDLE;
                if (full_q && !rd_i) begin
                  oerr_q <= 1'b1;
                end else begin
                  data_q <= nxt_data;
                  perr_q <= nxt_perr;
                  ferr_q <= !rxd_i;
                  full_q <= 1'b1;
                end
              end else begin
                vec_q[idx_q] <= rxd_i;
                idx_q        <= idx_q + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
  assign oerr_o = oerr_q;
endmodule

// File: rtl/sp_port.sv
module sp_port
  import sp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       cfg_len8_i,
  input  logic       cfg_par_en_i,
  input  logic       cfg_par_odd_i,
  input  logic       cfg_stop2_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_wr_i,
  output logic       tx_empty_o,
  output logic       tx_end_o,
  output logic       txd_o,
  input  logic       rxd_i,
  input  logic       rx_rd_i,
  output logic [7:0] rx_data_o,
  output logic       rx_full_o,
  output logic       rx_perr_o,
  output logic       rx_ferr_o,
  output logic       rx_oerr_o
);
  sp_cfg_t cfg;
  logic    rxd_s;

  assign cfg = '{len8: cfg_len8_i, par_en: cfg_par_en_i,
                 par_odd: cfg_par_odd_i, stop2: cfg_stop2_i};

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rxd_s = rxd_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '1;
        else         sq <= SYNC_STAGES'({sq, rxd_i});
      end
      assign rxd_s = sq[SYNC_STAGES-1];
    end
  endgenerate

  sp_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick16_i),
    .cfg_i   (cfg),
    .wr_i    (tx_wr_i),
    .data_i  (tx_data_i),
    .txd_o   (txd_o),
    .empty_o (tx_empty_o),
    .end_o   (tx_end_o)
  );

  sp_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick16_i),
    .cfg_i  (cfg),
    .rxd_i  (rxd_s),
    .rd_i   (rx_rd_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o),
    .perr_o (rx_perr_o),
    .ferr_o (rx_ferr_o),
    .oerr_o (rx_oerr_o)
  );
endmodule

// File: rtl/sp_port_chk.sv
module sp_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_len8_i,
  input logic       tx_wr_i,
  input logic       tx_empty_o,
  input logic       tx_end_o,
  input logic       txd_o,
  input logic       rx_rd_i,
  input logic [7:0] rx_data_o,
  input logic       rx_full_o,
  input logic       rx_oerr_o
);
  a_r1_idle_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_o |-> txd_o);

  a_r6_end_needs_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_o |-> tx_empty_o);

  a_r5_fill_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_empty_o) |-> $past(tx_wr_i));

  a_r11_keep_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rx_rd_i) |=> $stable(rx_data_o));

  a_r11_oerr_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_oerr_o) |-> $past(rx_full_o));

  a_r12_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rx_full_o) && !cfg_len8_i) |-> !rx_data_o[7]);
endmodule

bind sp_port sp_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_len8_i (cfg_len8_i),
  .tx_wr_i    (tx_wr_i),
  .tx_empty_o (tx_empty_o),
  .tx_end_o   (tx_end_o),
  .txd_o      (txd_o),
  .rx_rd_i    (rx_rd_i),
  .rx_data_o  (rx_data_o),
  .rx_full_o  (rx_full_o),
  .rx_oerr_o  (rx_oerr_o)
);

// File: tb/sp_port_tb.sv
module sp_port_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       l8 = 1'b1, pe = 1'b0, po = 1'b0, s2 = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_wr = 1'b0;
  logic       tx_empty, tx_end, txd;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, rx_perr, rx_ferr, rx_oerr;
  logic       loop_en = 1'b0, bench_rxd = 1'b1;
  logic       rxd;
  int         tdiv = 0;
  int         checks = 0, errors = 0;
  bit         done = 0;

  assign rxd = loop_en ? txd : bench_rxd;

  sp_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick16),
    .cfg_len8_i(l8), .cfg_par_en_i(pe), .cfg_par_odd_i(po), .cfg_stop2_i(s2),
    .tx_data_i(tx_data), .tx_wr_i(tx_wr), .tx_empty_o(tx_empty), .tx_end_o(tx_end),
    .txd_o(txd), .rxd_i(rxd), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .rx_full_o(rx_full), .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr), .rx_oerr_o(rx_oerr)
  );

  // one tick every four clocks
  always @(negedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic f8, fp, fo, f2,
                                            output int n);
    int nd = f8 ? 8 : 7;
    int ones = 0;
    logic [11:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (fp) f[nd+1] = ((ones % 2) == 1) ^ fo;
    n = 2 + nd + int'(fp) + int'(f2);
    return f;
  endfunction

  task automatic set_fmt(input int k);
    @(negedge clk);
    l8 = k[0];
    pe = ((k / 2) % 3) != 0;
    po = ((k / 2) % 3) == 2;
    s2 = (k / 6) != 0;
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic tx_decode(input logic [7:0] d, input string req, output int gap);
    int n;
    logic [11:0] f;
    f = exp_frame(d, l8, pe, po, s2, n);
    gap = 0;
    while (txd) begin @(negedge clk); gap++; end
    repeat (30) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(txd == f[i], req, int'(txd), int'(f[i]));
      if (i < n - 1) repeat (64) @(negedge clk);
    end
  endtask

  task automatic rx_drive(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int n;
    int nd = l8 ? 8 : 7;
    logic [11:0] f;
    f = exp_frame(d, l8, pe, po, s2, n);
    if (bad_par && pe) f[nd+1] = ~f[nd+1];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bad_stop && i == nd + 1 + int'(pe)) begin
        bench_rxd = 1'b0;
        repeat (48) @(negedge clk);
        bench_rxd = 1'b1;
        repeat (15) @(negedge clk);
      end else begin
        bench_rxd = f[i];
        repeat (63) @(negedge clk);
      end
    end
    @(negedge clk); bench_rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic rx_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic rx_expect(input logic [7:0] d, input bit ep, input bit ef, input string req);
    logic [7:0] e = l8 ? d : {1'b0, d[6:0]};
    chk(rx_full == 1'b1, {req, " full"}, int'(rx_full), 1);
    chk(rx_data == e, {req, " data"}, int'(rx_data), int'(e));
    chk(rx_perr == ep, {req, " perr"}, int'(rx_perr), int'(ep));
    chk(rx_ferr == ef, {req, " ferr"}, int'(rx_ferr), int'(ef));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap;
    logic [7:0] a, b, c;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(tx_empty && tx_end, "R1 tx flags", int'({tx_empty, tx_end}), 3);
    chk(rx_full == 1'b0, "R1 rx_full", int'(rx_full), 0);

    // R2 R3 R4: every format on the transmit side
    for (int k = 0; k < 12; k++) begin
      set_fmt(k);
      a = 8'($urandom);
      tx_write(a);
      tx_decode(a, "R2 R3 R4 tx frame", gap);
      wait (tx_end);
      @(negedge clk);
      chk(tx_end && txd, "R6 end after frame", int'({tx_end, txd}), 3);
    end

    // R5 R6: queued frames, write while full ignored
    set_fmt(0);
    l8 = 1'b1;
    a = 8'hA5; b = 8'h3C; c = 8'hFF;
    tx_write(a);
    wait (tx_empty);
    tx_write(b);
    chk(tx_empty == 1'b0, "R5 holding full", int'(tx_empty), 0);
    tx_write(c);
    chk(tx_end == 1'b0, "R6 busy", int'(tx_end), 0);
    tx_decode(a, "R5 first frame", gap);
    tx_decode(b, "R5 second frame", gap);
    chk(gap <= 40, "R5 no gap", gap, 40);
    repeat (40) @(negedge clk);
    chk(tx_end == 1'b1, "R6 end after queue", int'(tx_end), 1);
    begin
      bit stayed = 1;
      repeat (800) begin @(negedge clk); if (!txd) stayed = 0; end
      chk(stayed, "R5 ignored write sent nothing", int'(stayed), 1);
    end

    // R3 R8 R12: every format on the receive side
    for (int k = 0; k < 12; k++) begin
      set_fmt(k);
      a = (k == 2) ? 8'hFF : 8'($urandom);
      rx_drive(a, 0, 0);
      rx_expect(a, 0, 0, "R3 R8 R12 rx");
      if (!l8) chk(rx_data[7] == 1'b0, "R12 msb", int'(rx_data[7]), 0);
      rx_read();
      @(negedge clk);
      chk(rx_full == 1'b0, "R8 read clears", int'(rx_full), 0);
    end

    // R9 parity error, even then odd
    set_fmt(3);
    a = 8'($urandom);
    rx_drive(a, 1, 0);
    rx_expect(a, 1, 0, "R9 even");
    rx_read();
    set_fmt(5);
    rx_drive(a, 1, 0);
    rx_expect(a, 1, 0, "R9 odd");
    rx_read();

    // R10 framing error
    set_fmt(1);
    a = 8'h5A;
    rx_drive(a, 0, 1);
    rx_expect(a, 0, 1, "R10");
    rx_read();
    repeat (100) @(negedge clk);
    chk(rx_full == 1'b0, "R10 no stray frame", int'(rx_full), 0);

    // R7 glitch rejected, following frame still taken
    @(negedge clk); bench_rxd = 1'b0;
    repeat (8) @(negedge clk); bench_rxd = 1'b1;
    repeat (1000) @(negedge clk);
    chk(rx_full == 1'b0, "R7 glitch", int'(rx_full), 0);
    a = 8'hC3;
    rx_drive(a, 0, 0);
    rx_expect(a, 0, 0, "R7 after glitch");

    // R11 overrun keeps first character
    b = 8'h81;
    rx_drive(b, 0, 0);
    chk(rx_oerr == 1'b1, "R11 oerr", int'(rx_oerr), 1);
    chk(rx_data == a, "R11 keep data", int'(rx_data), int'(a));
    rx_read();
    @(negedge clk);
    chk(rx_oerr == 1'b0 && rx_full == 1'b0, "R11 read clears", int'({rx_oerr, rx_full}), 0);

    // R13 full duplex: loopback, then independent frames in both directions
    loop_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      set_fmt(int'($urandom % 12));
      a = 8'($urandom);
      tx_write(a);
      wait (rx_full);
      repeat (2) @(negedge clk);
      rx_expect(a, 0, 0, "R13 loopback");
      rx_read();
      wait (tx_end);
    end
    loop_en = 1'b0;
    set_fmt(7);
    a = 8'h6B; b = 8'h94;
    fork
      begin tx_write(a); tx_decode(a, "R13 tx while rx", gap); end
      rx_drive(b, 0, 0);
    join
    rx_expect(b, 0, 0, "R13 rx while tx");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule